// File: doc/BRIEF.md
# Serial Configuration Flash Command Responder

This block plays the device side of a small serial configuration flash at byte granularity. The host side hands over one byte per transfer strobe, together with a chip-select hold flag. After each accepted byte the block returns a response byte, which stays on its output until the next accepted byte. The first byte of each hold period is taken as the opcode. The bytes that follow are interpreted under that opcode. Five operations are supported: a byte-wise storage read with a 24-bit address, setting and clearing the write-enable latch, reading the status register, and reading a fixed three-byte identity.

The storage is an internal byte array of parameterised size. It is filled through a simple load port, one byte per cycle, independently of the serial framing. Any address at or beyond the array size reads as zero. The address register is a full 24 bits wide and wraps on increment. A byte sent with the hold flag low is still handled under the current opcode, and it closes the frame. The next byte with hold high therefore opens a new frame.

Top module: `flash_cmd_responder`

## Requirements
- R1: A byte accepted with hold high while the previous hold state was clear is latched as the opcode. The response becomes 0x00 and the address clears.
- R2: Under opcode 0x03 the next three bytes form the address, most significant byte first. The response is 0x00 after each of them.
- R3: Each later byte of an 0x03 frame returns storage[address], and the address then increments by one.
- R4: A storage read at an address greater than or equal to MEM_BYTES returns 0x00.
- R5: The address is 24 bits wide. Incrementing from 0xFFFFFF wraps it to 0x000000.
- R6: Opcode 0x06 sets status bit 1, so the status reads 0x02. Opcode 0x04 clears that bit. The response for both is 0x00.
- R7: Under opcode 0x05 every data byte returns the current status register.
- R8: Under opcode 0x9F the first three data bytes return 0x20, 0x40 and 0x12. Every later byte returns 0x00.
- R9: A byte sent with hold low is processed under the current opcode and clears the hold state. The next byte sent with hold high is then taken as a fresh opcode.
- R10: After reset the status register is 0x00, the response is 0x00 and the unknown-opcode flag is low.
- R11: A data byte under an unsupported opcode leaves the response unchanged and raises the unknown-opcode flag. The next opcode byte clears the flag.
- R12: A load-port write of data d at index i makes a later storage read of address i return d.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_valid | input | 1 | One byte is presented this cycle |
| xfer_byte | input | 8 | Byte received from the host |
| xfer_hold | input | 1 | Chip-select hold flag for this byte |
| rsp_byte | output | 8 | Response byte from the last accepted transfer |
| unknown_op | output | 1 | A data byte arrived under an unsupported opcode |
| load_en | input | 1 | Storage load strobe |
| load_idx | input | IDX_W | Storage load index |
| load_data | input | 8 | Storage load byte |

## Verification
Closing a frame and executing a byte can fall in the same cycle. A byte sent with hold low must still run under the old opcode while the hold state drops. The bench provokes this in the middle of a read sweep and checks two things: the returned byte is still the next storage byte, and the following byte with hold high is decoded as a new opcode. A second coincidence is an address increment that crosses the top of the 24-bit range while also lying outside storage. The bench starts a read at 0xFFFFFF and expects 0x00, then mem[0], then mem[1].

// File: rtl/flashrsp_pkg.sv
package flashrsp_pkg;

    typedef enum logic [7:0] {
        OPC_READ   = 8'h03,
        OPC_WRDIS  = 8'h04,
        OPC_STATUS = 8'h05,
        OPC_WREN   = 8'h06,
        OPC_IDENT  = 8'h9F
    } opcode_e;

    localparam int POS_W   = 3;
    localparam int ADR_W   = 24;
    localparam int WEL_BIT = 1;

    typedef logic [POS_W-1:0] pos_t;
    typedef logic [ADR_W-1:0] adr_t;

    typedef struct packed {
        logic new_frame;
        logic exec;
    } frame_ev_t;

    function automatic logic [7:0] ident_byte(input pos_t p);
        case (p)
            3'd1:    return 8'h20;
            3'd2:    return 8'h40;
            3'd3:    return 8'h12;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/flashrsp_frame.sv
module flashrsp_frame
    import flashrsp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       valid,
    input  logic       hold,
    input  logic [7:0] byte_in,
    output frame_ev_t  ev,
    output logic [7:0] opcode,
    output logic       hold_q
);

    always_comb begin
        ev.new_frame = valid && hold && !hold_q;
        ev.exec      = valid && !ev.new_frame;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= 1'b0;
            opcode <= 8'h00;
        end else if (ev.new_frame) begin
            hold_q <= 1'b1;
            opcode <= byte_in;
        end else if (valid && !hold) begin
            hold_q <= 1'b0;
        end
    end

    // R9: a byte with hold low closes the frame.
    assert_hold_drop_R9: assert property (@(posedge clk) disable iff (rst)
        (valid && !hold) |=> !hold_q);

    // R1: the opcode register follows the byte that opened the frame.
    assert_opcode_latch_R1: assert property (@(posedge clk) disable iff (rst)
        ev.new_frame |=> (opcode == $past(byte_in)));

endmodule

// File: rtl/flashrsp_store.sv
module flashrsp_store
    import flashrsp_pkg::*;
#(
    parameter int MEM_BYTES = 64,
    localparam int IDX_W = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1
) (
    input  logic             clk,
    input  logic             load_en,
    input  logic [IDX_W-1:0] load_idx,
    input  logic [7:0]       load_data,
    input  adr_t             rd_addr,
    output logic [7:0]       rd_data,
    output logic             rd_in_range
);

    logic [7:0] mem [MEM_BYTES];

    always_ff @(posedge clk) begin
        if (load_en && (int'(load_idx) < MEM_BYTES))
            mem[load_idx] <= load_data;
    end

    always_comb begin
        rd_in_range = (rd_addr < ADR_W'(MEM_BYTES));
        rd_data     = rd_in_range ? mem[rd_addr[IDX_W-1:0]] : 8'h00;
    end

endmodule

// File: rtl/flash_cmd_responder.sv
module flash_cmd_responder
    import flashrsp_pkg::*;
#(
    parameter int MEM_BYTES = 64,
    localparam int IDX_W = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             xfer_valid,
    input  logic [7:0]       xfer_byte,
    input  logic             xfer_hold,
    output logic [7:0]       rsp_byte,
    output logic             unknown_op,
    input  logic             load_en,
    input  logic [IDX_W-1:0] load_idx,
    input  logic [7:0]       load_data
);

    frame_ev_t  ev;
    logic [7:0] opcode;
    logic       hold_q;
    adr_t       addr;
    pos_t       pos;
    logic [7:0] status;
    logic [7:0] mem_byte;
    logic       mem_ok;

    flashrsp_frame u_frame (
        .clk     (clk),
        .rst     (rst),
        .valid   (xfer_valid),
        .hold    (xfer_hold),
        .byte_in (xfer_byte),
        .ev      (ev),
        .opcode  (opcode),
        .hold_q  (hold_q)
    );

    flashrsp_store #(.MEM_BYTES(MEM_BYTES)) u_store (
        .clk         (clk),
        .load_en     (load_en),
        .load_idx    (load_idx),
        .load_data   (load_data),
        .rd_addr     (addr),
        .rd_data     (mem_byte),
        .rd_in_range (mem_ok)
    );

    function automatic pos_t pos_step(input pos_t p);
        return (p >= pos_t'(4)) ? p : p + pos_t'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_byte   <= 8'h00;
            unknown_op <= 1'b0;
            addr       <= '0;
            pos        <= '0;
            status     <= 8'h00;
        end else if (ev.new_frame) begin
            rsp_byte   <= 8'h00;
            unknown_op <= 1'b0;
            addr       <= '0;
            pos        <= pos_t'(1);
        end else if (ev.exec) begin
            case (opcode)
                OPC_READ: begin
                    if (pos < pos_t'(4)) begin
                        addr     <= {addr[ADR_W-9:0], xfer_byte};
                        rsp_byte <= 8'h00;
                    end else begin
                        rsp_byte <= mem_byte;
                        addr     <= addr + adr_t'(1);
                    end
                    pos <= pos_step(pos);
                end
                OPC_WRDIS: begin
                    status[WEL_BIT] <= 1'b0;
                    rsp_byte        <= 8'h00;
                end
                OPC_STATUS: rsp_byte <= status;
                OPC_WREN: begin
                    status[WEL_BIT] <= 1'b1;
                    rsp_byte        <= 8'h00;
                end
                OPC_IDENT: begin
                    rsp_byte <= ident_byte(pos);
                    pos      <= pos_step(pos);
                end
                default: unknown_op <= 1'b1;
            endcase
        end
    end

    // R1: opening a frame clears the response.
    assert_open_clears_R1: assert property (@(posedge clk) disable iff (rst)
        ev.new_frame |=> (rsp_byte == 8'h00));

    // R4: an out-of-range storage read answers zero.
    assert_oob_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (ev.exec && opcode == OPC_READ && pos >= pos_t'(4) && !mem_ok)
        |=> (rsp_byte == 8'h00));

    // R6: write enable leaves the latch set.
    assert_wel_set_R6: assert property (@(posedge clk) disable iff (rst)
        (ev.exec && opcode == OPC_WREN) |=> status[WEL_BIT]);

    // R6: only the write-enable bit can ever be set.
    assert_status_bits_R6: assert property (@(posedge clk) disable iff (rst)
        (status & ~8'h02) == 8'h00);

    // R11: an unsupported opcode does not disturb the response.
    assert_unknown_stable_R11: assert property (@(posedge clk) disable iff (rst)
        (ev.exec && opcode != OPC_READ && opcode != OPC_WRDIS &&
         opcode != OPC_STATUS && opcode != OPC_WREN && opcode != OPC_IDENT)
        |=> ($stable(rsp_byte) && unknown_op));

    // R9: hold state tracked by the framer is unused here beyond checks.
    assert_frame_open_R9: assert property (@(posedge clk) disable iff (rst)
        ev.new_frame |=> hold_q);

endmodule

// File: tb/flash_cmd_responder_test.sv
module flash_cmd_responder_test;

    localparam int MEMB = 64;
    localparam int IW   = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          xfer_valid = 1'b0;
    logic [7:0]    xfer_byte  = 8'h00;
    logic          xfer_hold  = 1'b0;
    logic [7:0]    rsp_byte;
    logic          unknown_op;
    logic          load_en = 1'b0;
    logic [IW-1:0] load_idx = '0;
    logic [7:0]    load_data = 8'h00;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    flash_cmd_responder #(.MEM_BYTES(MEMB)) uut (
        .clk(clk), .rst(rst), .xfer_valid(xfer_valid), .xfer_byte(xfer_byte),
        .xfer_hold(xfer_hold), .rsp_byte(rsp_byte), .unknown_op(unknown_op),
        .load_en(load_en), .load_idx(load_idx), .load_data(load_data)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    function automatic logic [7:0] model(input int a);
        return (a >= 0 && a < MEMB) ? pat(a) : 8'h00;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b, input logic h);
        @(negedge clk);
        xfer_valid = 1'b1;
        xfer_byte  = b;
        xfer_hold  = h;
        @(posedge clk);
        #1;
        xfer_valid = 1'b0;
    endtask

    task automatic close_frame();
        send(8'h00, 1'b0);
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R10 rsp", rsp_byte, 8'h00);
        chk("R10 unk", {7'd0, unknown_op}, 8'h00);

        // R12: fill storage through the load port
        for (int i = 0; i < MEMB; i++) begin
            @(negedge clk);
            load_en = 1'b1; load_idx = IW'(i); load_data = pat(i);
        end
        @(negedge clk);
        load_en = 1'b0;

        // R10 / R7: status after reset
        send(8'h05, 1'b1);
        send(8'h00, 1'b1);
        chk("R10 status", rsp_byte, 8'h00);
        close_frame();

        // R6 then R7
        send(8'h06, 1'b1);
        send(8'h55, 1'b0);
        chk("R6 wren rsp", rsp_byte, 8'h00);
        send(8'h05, 1'b1);
        for (int k = 0; k < 3; k++) begin
            send(8'hFF, 1'b1);
            chk("R7 status set", rsp_byte, 8'h02);
        end
        close_frame();
        send(8'h04, 1'b1);
        send(8'h00, 1'b0);
        chk("R6 wrdis rsp", rsp_byte, 8'h00);
        send(8'h05, 1'b1);
        send(8'h00, 1'b0);
        chk("R7 status clr", rsp_byte, 8'h00);

        // R8 identity
        send(8'h9F, 1'b1);
        chk("R1 open", rsp_byte, 8'h00);
        send(8'h00, 1'b1); chk("R8 id1", rsp_byte, 8'h20);
        send(8'h00, 1'b1); chk("R8 id2", rsp_byte, 8'h40);
        send(8'h00, 1'b1); chk("R8 id3", rsp_byte, 8'h12);
        send(8'h00, 1'b1); chk("R8 id4", rsp_byte, 8'h00);
        send(8'h00, 1'b0); chk("R8 id5", rsp_byte, 8'h00);

        // R2 / R3 / R4 sweep over start addresses
        for (int s = 0; s < MEMB + 2; s++) begin
            send(8'h03, 1'b1);
            send(8'h00, 1'b1); chk("R2 a2", rsp_byte, 8'h00);
            send(8'h00, 1'b1); chk("R2 a1", rsp_byte, 8'h00);
            send(8'(s), 1'b1); chk("R2 a0", rsp_byte, 8'h00);
            for (int k = 0; k < 3; k++) begin
                send(8'h00, (k != 2));
                chk((s + k < MEMB) ? "R3 data" : "R4 oob", rsp_byte, model(s + k));
            end
        end

        // R2 byte order: high byte nonzero is out of range
        send(8'h03, 1'b1);
        send(8'h2A, 1'b1); send(8'h00, 1'b1); send(8'h00, 1'b1);
        send(8'h00, 1'b0);
        chk("R2 msb first", rsp_byte, 8'h00);
        send(8'h03, 1'b1);
        send(8'h00, 1'b1); send(8'h00, 1'b1); send(8'h2A, 1'b1);
        send(8'h00, 1'b0);
        chk("R2 lsb last", rsp_byte, pat(42));

        // R5 wrap
        send(8'h03, 1'b1);
        send(8'hFF, 1'b1); send(8'hFF, 1'b1); send(8'hFF, 1'b1);
        send(8'h00, 1'b1); chk("R4 top", rsp_byte, 8'h00);
        send(8'h00, 1'b1); chk("R5 wrap0", rsp_byte, pat(0));
        send(8'h00, 1'b0); chk("R5 wrap1", rsp_byte, pat(1));

        // R9: hold-low byte still served, next hold-high byte is opcode
        send(8'h03, 1'b1);
        send(8'h00, 1'b1); send(8'h00, 1'b1); send(8'h07, 1'b1);
        send(8'h00, 1'b1); chk("R9 pre", rsp_byte, pat(7));
        send(8'h00, 1'b0); chk("R9 last byte", rsp_byte, pat(8));
        send(8'h9F, 1'b1); chk("R9 new opcode", rsp_byte, 8'h00);
        send(8'h00, 1'b0); chk("R9 new frame", rsp_byte, 8'h20);

        // R12: reload one location and read it back
        @(negedge clk);
        load_en = 1'b1; load_idx = IW'(5); load_data = 8'hC3;
        @(negedge clk);
        load_en = 1'b0;
        send(8'h03, 1'b1);
        send(8'h00, 1'b1); send(8'h00, 1'b1); send(8'h05, 1'b1);
        send(8'h00, 1'b0);
        chk("R12 reload", rsp_byte, 8'hC3);

        // R11 unknown opcode
        send(8'hAB, 1'b1);
        send(8'h77, 1'b1);
        chk("R11 rsp held", rsp_byte, 8'h00);
        chk("R11 flag", {7'd0, unknown_op}, 8'h01);
        send(8'h77, 1'b0);
        chk("R11 rsp held2", rsp_byte, 8'h00);
        send(8'h05, 1'b1);
        chk("R11 flag clr", {7'd0, unknown_op}, 8'h00);
        close_frame();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule